// File: doc/BRIEF.md
# Receive Frame Byte Buffer with Termination Status

This block sits between a bit-level frame deframer and a host. The deframer hands it one payload byte at a time, with sideband markers for the first byte of a frame, the last byte of a frame, whether the frame check passed, and whether the frame was cut short by an abort sequence. The block holds up to 64 bytes. With each byte it stores a last-byte tag and a 3-bit termination code.

The host sees the oldest byte on `rdData` and removes it with a one-cycle `rdStrobe`. Several real-time indications tell the host how to drain the buffer safely:
- a not-empty flag;
- a flag that is high while the fill level exceeds a host-set threshold;
- a count of bytes that can be read without crossing into the next frame;
- a message-status bit that drops when a frame end is buffered;
- a 3-bit termination code captured at each read.

When the buffer is full and another byte arrives, the block drops that byte and closes the open frame with an overrun code. It then discards the rest of that frame.

Top module: `rx_frame_fifo`

## Requirements
- R1: After reset:
  - `notEmpty` = 0, `aboveHwm` = 0 and `bytesAvail` = 0;
  - `pktStatus` = 3'b000;
  - `msgStatus` = 1.
- R2: Bytes are delivered in arrival order. `rdData` shows the oldest stored byte. `notEmpty` is 1 exactly while at least one byte is stored.
- R3: `aboveHwm` is 1 exactly while the number of stored bytes is strictly greater than `hwmLevel`.
- R4: A byte written with `inEnd`=1 closes its frame and carries a termination code:
  - 3'b011 (abort) when `inAbort`=1, whatever the value of `inCrcOk`;
  - otherwise 3'b001 (good) when `inCrcOk`=1;
  - otherwise 3'b010 (bad check).
- R5: Each accepted read sets `pktStatus` on the following clock edge:
  - to the termination code of the byte read, when that byte is the last byte of a frame;
  - to 3'b000 (frame in progress) otherwise.

  Between reads, `pktStatus` holds its value.
- R6: `bytesAvail` counts the stored bytes from the oldest up to and including the first last-of-frame byte. When no frame end is stored, it counts all stored bytes.
- R7: `msgStatus` is 0 while any last-of-frame byte is stored. It is 1 otherwise, which includes the empty state.
- R8: A byte that arrives while 64 bytes are stored is dropped. If the current frame has stored bytes, its newest stored byte becomes a frame end with code 3'b100 (overrun). Further bytes of that frame are then dropped until its end byte, which is also dropped. A byte marked `inStart` is accepted again.
- R9: A `rdStrobe` while the buffer is empty is ignored. The stored count stays 0 and `pktStatus` keeps its value.
- R10: The buffer accepts exactly 64 bytes before it overruns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A payload byte is presented this cycle |
| inData | input | 8 | Payload byte |
| inStart | input | 1 | Byte is the first of a frame |
| inEnd | input | 1 | Byte is the last of a frame |
| inCrcOk | input | 1 | Frame check passed (meaningful with inEnd) |
| inAbort | input | 1 | Frame ended by abort (meaningful with inEnd) |
| rdStrobe | input | 1 | Host removes the oldest byte |
| hwmLevel | input | 7 | Fill threshold for aboveHwm |
| rdData | output | 8 | Oldest stored byte |
| notEmpty | output | 1 | At least one byte stored |
| aboveHwm | output | 1 | Fill level above hwmLevel |
| pktStatus | output | 3 | Termination code as of the last read |
| msgStatus | output | 1 | 0 when a frame end is buffered |
| bytesAvail | output | 7 | Bytes readable up to the next frame end |

## Verification
A byte presented with `inValid` is stored at the next rising edge. From that edge, `notEmpty`, `aboveHwm`, `bytesAvail` and `msgStatus` reflect it through combinational logic, so they are due one edge after the stimulus. A read removes its byte at the edge where `rdStrobe` is high, and `pktStatus` takes its new value at that same edge. `rdData` is compared before the strobe.

The bench drives inputs on falling edges and samples every output at the following falling edge, which places each sample half a period after the edge that updated it. A queue model is updated in the same driver call and supplies the expected values. That model includes the overrun and discard rules.

// File: rtl/rx_frame_fifo_pkg.sv
package rx_frame_fifo_pkg;

  // termination codes seen by the host
  typedef enum logic [2:0] {
    PS_BUSY    = 3'd0,
    PS_GOOD    = 3'd1,
    PS_BADCRC  = 3'd2,
    PS_ABORT   = 3'd3,
    PS_OVERRUN = 3'd4
  } pktCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     wrEn;
    logic     wrLast;
    pktCode_e wrCode;
    logic     markOverrun;
    logic     rdEn;
  } fifoCmd_t;

endpackage

// File: rtl/rx_frame_fifo_dp.sv
module rx_frame_fifo_dp
  import rx_frame_fifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  hwmLevel,
  output logic [DATA_W-1:0] rdData,
  output logic              headLast,
  output pktCode_e          headCode,
  output logic              full,
  output logic              empty,
  output logic              aboveHwm,
  output logic [CNT_W-1:0]  bytesAvail,
  output logic              endBuffered
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] dataMem [DEPTH];
  pktCode_e          codeMem [DEPTH];
  logic [DEPTH-1:0]  lastMem;
  logic [PTR_W-1:0]  wrPtr, rdPtr, prevWr;
  logic [CNT_W-1:0]  count;

  assign prevWr = wrPtr - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      lastMem <= '0;
    end else begin
      if (cmd.wrEn) begin
        wrPtr          <= wrPtr + 1'b1;
        lastMem[wrPtr] <= cmd.wrLast;
      end
      if (cmd.markOverrun) lastMem[prevWr] <= 1'b1;
      if (cmd.rdEn) rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(cmd.wrEn) - CNT_W'(cmd.rdEn);
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.wrEn) begin
      dataMem[wrPtr] <= wrData;
      codeMem[wrPtr] <= cmd.wrCode;
    end
    if (cmd.markOverrun) codeMem[prevWr] <= PS_OVERRUN;
  end

  assign rdData   = dataMem[rdPtr];
  assign headLast = lastMem[rdPtr];
  assign headCode = codeMem[rdPtr];
  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign aboveHwm = (count > hwmLevel);

  // scan from the head: the nearest frame end bounds the readable run
  always_comb begin
    bytesAvail  = count;
    endBuffered = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CNT_W'(i) < count && lastMem[rdPtr + PTR_W'(i)]) begin
        bytesAvail  = CNT_W'(i + 1);
        endBuffered = 1'b1;
      end
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrEn && !cmd.rdEn) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R6
  avail_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !empty |-> (bytesAvail != '0 && bytesAvail <= count));

endmodule

// File: rtl/rx_frame_fifo_ctrl.sv
module rx_frame_fifo_ctrl
  import rx_frame_fifo_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inStart,
  input  logic     inEnd,
  input  logic     inCrcOk,
  input  logic     inAbort,
  input  logic     rdStrobe,
  input  logic     full,
  input  logic     empty,
  input  logic     headLast,
  input  pktCode_e headCode,
  output fifoCmd_t cmd,
  output pktCode_e pktStatus
);

  logic     discard;
  logic     pktOpen;
  pktCode_e statusReg;
  logic     dropping;

  assign dropping  = discard && !inStart;
  assign pktStatus = statusReg;

  always_comb begin
    cmd             = '0;
    cmd.wrCode      = inAbort ? PS_ABORT : (inCrcOk ? PS_GOOD : PS_BADCRC);
    cmd.wrLast      = inEnd;
    cmd.rdEn        = rdStrobe && !empty;
    if (inValid && !dropping) begin
      if (full) cmd.markOverrun = pktOpen;
      else      cmd.wrEn        = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      discard   <= 1'b0;
      pktOpen   <= 1'b0;
      statusReg <= PS_BUSY;
    end else begin
      if (inValid) begin
        if (dropping) begin
          if (inEnd) discard <= 1'b0;
        end else if (full) begin
          discard <= pktOpen && !inEnd;
          pktOpen <= 1'b0;
        end else begin
          discard <= 1'b0;
          pktOpen <= !inEnd;
        end
      end
      if (cmd.rdEn) statusReg <= headLast ? headCode : PS_BUSY;
    end
  end

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.rdEn |=> $stable(pktStatus));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rdEn |-> !empty);

  // R8
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrEn |-> !full);

  // R8
  overrun_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.markOverrun |-> !empty);

endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
  import rx_frame_fifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inStart,
  input  logic              inEnd,
  input  logic              inCrcOk,
  input  logic              inAbort,
  input  logic              rdStrobe,
  input  logic [CNT_W-1:0]  hwmLevel,
  output logic [DATA_W-1:0] rdData,
  output logic              notEmpty,
  output logic              aboveHwm,
  output logic [2:0]        pktStatus,
  output logic              msgStatus,
  output logic [CNT_W-1:0]  bytesAvail
);

  fifoCmd_t cmd;
  pktCode_e headCode, statusCode;
  logic     headLast, full, empty, endBuffered;

  rx_frame_fifo_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inStart   (inStart),
    .inEnd     (inEnd),
    .inCrcOk   (inCrcOk),
    .inAbort   (inAbort),
    .rdStrobe  (rdStrobe),
    .full      (full),
    .empty     (empty),
    .headLast  (headLast),
    .headCode  (headCode),
    .cmd       (cmd),
    .pktStatus (statusCode)
  );

  rx_frame_fifo_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .wrData      (inData),
    .hwmLevel    (hwmLevel),
    .rdData      (rdData),
    .headLast    (headLast),
    .headCode    (headCode),
    .full        (full),
    .empty       (empty),
    .aboveHwm    (aboveHwm),
    .bytesAvail  (bytesAvail),
    .endBuffered (endBuffered)
  );

  assign notEmpty  = !empty;
  assign msgStatus = !endBuffered;
  assign pktStatus = statusCode;

  // R7
  msg_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> msgStatus);

endmodule

// File: tb/test_rx_frame_fifo.sv
module test_rx_frame_fifo;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int data;
    bit last;
    int code;
  } entry_t;

  logic       clk = 0;
  logic       rstN = 0;
  logic       inValid = 0, inStart = 0, inEnd = 0, inCrcOk = 0, inAbort = 0;
  logic [7:0] inData = '0;
  logic       rdStrobe = 0;
  logic [6:0] hwmLevel = 7'd40;
  logic [7:0] rdData;
  logic       notEmpty, aboveHwm, msgStatus;
  logic [2:0] pktStatus;
  logic [6:0] bytesAvail;

  entry_t q[$];
  bit     mOpen = 0, mDiscard = 0;
  int     mStatus = 0;
  int     checks = 0, fails = 0;
  int     nextByte = 1;
  bit     done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_frame_fifo i_rx_frame_fifo (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inStart(inStart), .inEnd(inEnd), .inCrcOk(inCrcOk), .inAbort(inAbort),
    .rdStrobe(rdStrobe), .hwmLevel(hwmLevel), .rdData(rdData),
    .notEmpty(notEmpty), .aboveHwm(aboveHwm), .pktStatus(pktStatus),
    .msgStatus(msgStatus), .bytesAvail(bytesAvail)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // compare all real-time flags with the queue model
  task automatic checkFlags();
    int avail = q.size();
    bit hasEnd = 0;
    for (int i = q.size() - 1; i >= 0; i--)
      if (q[i].last) begin avail = i + 1; hasEnd = 1; end
    check("R2 notEmpty", notEmpty, q.size() != 0);
    check("R3 aboveHwm", aboveHwm, q.size() > hwmLevel);
    check("R6 bytesAvail", bytesAvail, avail);
    check("R7 msgStatus", msgStatus, !hasEnd);
  endtask

  // driver: present one byte and update the expected queue
  task automatic pushByte(bit st, bit en, bit ok, bit ab);
    @(negedge clk);
    inValid = 1; inData = 8'(nextByte); inStart = st; inEnd = en;
    inCrcOk = ok; inAbort = ab;
    if (mDiscard && !st) begin
      if (en) mDiscard = 0;
    end else if (q.size() == 64) begin
      if (mOpen) begin
        q[q.size() - 1].last = 1;
        q[q.size() - 1].code = 4;
      end
      mDiscard = mOpen && !en;
      mOpen = 0;
    end else begin
      entry_t e;
      e.data = nextByte & 255;
      e.last = en;
      e.code = ab ? 3 : (ok ? 1 : 2);
      q.push_back(e);
      mDiscard = 0;
      mOpen = !en;
    end
    nextByte++;
    @(negedge clk);
    inValid = 0; inStart = 0; inEnd = 0; inCrcOk = 0; inAbort = 0;
  endtask

  // monitor: pop the expected item and compare data and status
  task automatic readByte(string req);
    @(negedge clk);
    if (q.size() != 0) check({req, " rdData"}, rdData, q[0].data);
    rdStrobe = 1;
    @(negedge clk);
    rdStrobe = 0;
    if (q.size() != 0) begin
      mStatus = q[0].last ? q[0].code : 0;
      void'(q.pop_front());
    end
    check({req, " pktStatus"}, pktStatus, mStatus);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog: actual 1 expected 0");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 notEmpty", notEmpty, 0);
    check("R1 aboveHwm", aboveHwm, 0);
    check("R1 bytesAvail", bytesAvail, 0);
    check("R1 pktStatus", pktStatus, 0);
    check("R1 msgStatus", msgStatus, 1);
    rstN = 1;
    @(negedge clk);

    // R4 good frame of 3, then an open frame of 2
    pushByte(1, 0, 0, 0); pushByte(0, 0, 0, 0); pushByte(0, 1, 1, 0);
    checkFlags();
    pushByte(1, 0, 0, 0); pushByte(0, 0, 0, 0);
    checkFlags();
    for (int i = 0; i < 3; i++) begin readByte("R5"); checkFlags(); end
    // R4 bad check end, then abort end with crcOk also set
    pushByte(0, 1, 0, 0);
    checkFlags();
    pushByte(1, 0, 0, 0); pushByte(0, 1, 1, 1);
    for (int i = 0; i < 5; i++) begin readByte("R4"); checkFlags(); end

    // R9 read on empty
    readByte("R9");
    checkFlags();

    // R3 threshold crossing
    hwmLevel = 7'd5;
    for (int i = 0; i < 5; i++) pushByte(i == 0, 0, 0, 0);
    checkFlags();
    pushByte(0, 1, 1, 0);
    checkFlags();
    for (int i = 0; i < 6; i++) begin readByte("R3"); checkFlags(); end
    hwmLevel = 7'd40;

    // R10 fill to 64 without overrun
    for (int i = 0; i < 64; i++) pushByte(i == 0, 0, 0, 0);
    check("R10 bytesAvail", bytesAvail, 64);
    checkFlags();
    // R8 overrun, discard rest of frame including its end byte
    pushByte(0, 0, 0, 0);
    check("R8 msgStatus", msgStatus, 0);
    checkFlags();
    pushByte(0, 0, 0, 0);
    readByte("R8");
    pushByte(0, 0, 0, 0); pushByte(0, 1, 1, 0);
    checkFlags();
    // new frame accepted after discard
    pushByte(1, 0, 0, 0); readByte("R8"); pushByte(0, 1, 1, 0);
    checkFlags();
    while (q.size() != 0) begin readByte("R8"); checkFlags(); end

    done = 1;
    finishRun();
  end

endmodule